// File: doc/BRIEF.md
# Page Translation Buffer with Pass-Through Windows

This block turns 32-bit logical addresses into physical addresses. Two paths do the work. The first is a cache of recent 4 KB page translations with 22 fully associative entries. The second is a pair of programmable range windows that pass a whole region through with no translation. A window is checked ahead of the cache. A window hit is a hit in its own right and never touches the cache contents. Cache entries carry no address-space identifier, so software flushes the whole cache when it switches context.

A requester presents an address on the lookup port and gets the response one clock later. When a lookup finds no translation, the block reports a miss and holds it. While the miss is held, new lookups are refused. An external table walker then supplies the missing translation through the refill port, and that refill releases the block. The block does not walk the page tables, arbitrate a bus or sequence exceptions.

Control is a two-state machine:
- `ST_READY` accepts lookups. It moves to `ST_MISS` when an accepted lookup misses both the windows and the cache.
- `ST_MISS` refuses lookups. It returns to `ST_READY` when a refill arrives or a flush is applied.
- A flush forces `ST_READY` from either state.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `tlb_miss` is 0, `rsp_valid` is 0, `lk_ready` is 1, both windows are disabled, every cache entry is invalid and the replacement pointer is 0.
- R2: A window matches when it is enabled and `(lk_addr[31:24] ^ base) & ~mask` is zero; a mask bit of 1 means "don't care". A lookup that hits a window returns `rsp_hit`=1 and `rsp_paddr` equal to `lk_addr`. A write never raises `rsp_fault` on a window hit, even if the cache holds a write-protected entry for that page. Windows take precedence over the cache.
- R3: A lookup that hits a window neither allocates nor alters any cache entry.
- R4: An accepted lookup that hits a cache entry returns, one cycle later, `rsp_valid`=1, `rsp_hit`=1 and `rsp_paddr` = {entry physical page, `lk_addr[11:0]`}. `rsp_hit` and `rsp_fault` are 0 whenever `rsp_valid` is 0.
- R5: A write lookup (`lk_write`=1) that hits an entry with its write-protect bit set returns `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. A read lookup of the same entry hits normally.
- R6: An accepted lookup that misses returns `rsp_valid`=1 with `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0. It also sets `tlb_miss`, which stays 1 until a refill or a flush. While `tlb_miss` is 1, `lk_ready` is 0 and lookups are ignored, so `rsp_valid` stays 0.
- R7: A refill clears a held miss at the next edge. When no valid entry has the refill's logical page, the refill goes into the lowest-numbered invalid entry.
- R8: When all 22 entries are valid, a refill replaces the entry at the round-robin pointer. The pointer then advances, wrapping from 21 to 0. Refills that use a free entry or an existing entry leave the pointer where it is.
- R9: A refill whose logical page already sits in a valid entry overwrites that entry in place, so no page is ever held twice.
- R10: A flush invalidates every entry, resets the pointer to 0 and clears `tlb_miss`. A lookup or refill presented in the same cycle as a flush is dropped.
- R11: A configuration write loads the base, mask and enable of the window selected by `cfg_sel` (0 or 1). Lookups accepted at later edges use the new values. A flush does not change the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address to translate |
| lk_write | input | 1 | Lookup is for a write access |
| lk_ready | output | 1 | Lookups are being accepted |
| rsp_valid | output | 1 | Response for the lookup accepted at the previous edge |
| rsp_hit | output | 1 | Translation found (window or cache) |
| rsp_fault | output | 1 | Write hit a write-protected entry |
| rsp_paddr | output | 32 | Physical address of the last response |
| tlb_miss | output | 1 | Held miss, waiting for a refill |
| rf_valid | input | 1 | Refill strobe from the table walker |
| rf_lpn | input | 20 | Refill logical page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_wp | input | 1 | Refill write-protect bit |
| flush | input | 1 | Invalidate the whole cache |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_sel | input | 1 | Window selected by the write |
| cfg_base | input | 8 | Window base for address bits [31:24] |
| cfg_mask | input | 8 | Window don't-care mask |
| cfg_en | input | 1 | Window enable |

## Verification
The in-line assertions check these properties on every cycle:
- a held miss appears together with a miss response;
- a held miss blocks the next response;
- a refill releases the miss;
- a flush empties the cache;
- window hits return the identity address and leave the valid bits untouched;
- no two entries ever match one lookup.

Other properties depend on history that no single-cycle property can see, so only the bench's scenarios show them:
- which entry a refill lands in;
- the order in which the round-robin pointer evicts entries once the cache is full;
- write-protect faults on specific pages;
- the effect of a window being disabled after it was used.

The bench covers these with a reference model and with sequences that fill the cache, evict from it, re-map a page and reprogram the windows.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_MISS  = 1'b1
    } xlat_state_e;
endpackage

// File: rtl/xlat_window.sv
module xlat_window #(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_base,
    input  logic [TAG_W-1:0] wr_mask,
    input  logic             wr_enable,
    input  logic [TAG_W-1:0] tag,
    output logic             match
);
    logic [TAG_W-1:0] base_q;
    logic [TAG_W-1:0] mask_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            base_q <= wr_base;
            mask_q <= wr_mask;
            en_q   <= wr_enable;
        end
    end

    // Bits set in the mask are excluded from the comparison.
    assign match = en_q && (((tag ^ base_q) & ~mask_q) == '0);

    assert_disabled_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !match);
endmodule

// File: rtl/xlat_tlb_array.sv
module xlat_tlb_array #(
    parameter int NUM_ENTRIES = 22,
    parameter int LPN_W       = 20,
    parameter int PPN_W       = 20,
    parameter int IDX_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [LPN_W-1:0]       lk_lpn,
    output logic                   hit,
    output logic [PPN_W-1:0]       hit_ppn,
    output logic                   hit_wp,
    input  logic                   wr_en,
    input  logic [LPN_W-1:0]       wr_lpn,
    input  logic [PPN_W-1:0]       wr_ppn,
    input  logic                   wr_wp,
    output logic [NUM_ENTRIES-1:0] valid_vec
);
    logic [NUM_ENTRIES-1:0] valid_q;
    logic [LPN_W-1:0]       lpn_q [NUM_ENTRIES];
    logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] wp_q;
    logic [IDX_W-1:0]       rr_q;

    logic [NUM_ENTRIES-1:0] match_vec;
    logic [NUM_ENTRIES-1:0] dup_vec;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = valid_q[i] && (lpn_q[i] == lk_lpn);
        assign dup_vec[i]   = valid_q[i] && (lpn_q[i] == wr_lpn);
    end

    // Read side: pick the lowest matching index.
    logic [IDX_W-1:0] hit_idx;
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit     = |match_vec;
    assign hit_ppn = ppn_q[hit_idx];
    assign hit_wp  = wp_q[hit_idx];

    // Write side: existing page, else lowest free slot, else round-robin victim.
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             dup_found;
    logic             free_found;
    logic [IDX_W-1:0] tgt_idx;
    logic             use_rr;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (dup_vec[i])  dup_idx  = IDX_W'(i);
            if (!valid_q[i]) free_idx = IDX_W'(i);
        end
        dup_found  = |dup_vec;
        free_found = ~&valid_q;
        use_rr     = !dup_found && !free_found;
        if (dup_found)       tgt_idx = dup_idx;
        else if (free_found) tgt_idx = free_idx;
        else                 tgt_idx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            wp_q    <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (wr_en) begin
            valid_q[tgt_idx] <= 1'b1;
            wp_q[tgt_idx]    <= wr_wp;
            if (use_rr) begin
                rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !flush && wr_en) begin
            lpn_q[tgt_idx] <= wr_lpn;
            ppn_q[tgt_idx] <= wr_ppn;
        end
    end

    assign valid_vec = valid_q;

    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0) && (rr_q == '0));
    assert_pointer_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q < IDX_W'(NUM_ENTRIES));
    assert_refill_never_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> ($countones(valid_q) >= $countones($past(valid_q))) && (valid_q != '0));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int NUM_ENTRIES = 22,
    parameter int WIN_BITS    = 8,
    parameter int NUM_WIN     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [ADDR_W-1:0]         lk_addr,
    input  logic                      lk_write,
    output logic                      lk_ready,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_fault,
    output logic [ADDR_W-1:0]         rsp_paddr,
    output logic                      tlb_miss,
    input  logic                      rf_valid,
    input  logic [ADDR_W-PAGE_BITS-1:0] rf_lpn,
    input  logic [ADDR_W-PAGE_BITS-1:0] rf_ppn,
    input  logic                      rf_wp,
    input  logic                      flush,
    input  logic                      cfg_we,
    input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] cfg_sel,
    input  logic [WIN_BITS-1:0]       cfg_base,
    input  logic [WIN_BITS-1:0]       cfg_mask,
    input  logic                      cfg_en
);
    localparam int LPN_W = ADDR_W - PAGE_BITS;
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    xlat_state_e state_q, state_d;

    // Window bank
    logic [NUM_WIN-1:0] win_match;
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_window #(.TAG_W(WIN_BITS)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_sel == SEL_W'(w))),
            .wr_base   (cfg_base),
            .wr_mask   (cfg_mask),
            .wr_enable (cfg_en),
            .tag       (lk_addr[ADDR_W-1 -: WIN_BITS]),
            .match     (win_match[w])
        );
    end
    // Lowest-numbered window first; any window overrides the cache.
    logic win_hit;
    assign win_hit = |win_match;

    // Page cache
    logic                   tlb_hit;
    logic [LPN_W-1:0]       tlb_ppn;
    logic                   tlb_wp;
    logic [NUM_ENTRIES-1:0] valid_vec;

    xlat_tlb_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .LPN_W       (LPN_W),
        .PPN_W       (LPN_W),
        .IDX_W       (IDX_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_lpn    (lk_addr[ADDR_W-1:PAGE_BITS]),
        .hit       (tlb_hit),
        .hit_ppn   (tlb_ppn),
        .hit_wp    (tlb_wp),
        .wr_en     (rf_valid && !flush),
        .wr_lpn    (rf_lpn),
        .wr_ppn    (rf_ppn),
        .wr_wp     (rf_wp),
        .valid_vec (valid_vec)
    );

    logic accept;
    logic look_miss;
    assign lk_ready  = (state_q == ST_READY);
    assign accept    = lk_valid && lk_ready && !flush;
    assign look_miss = !win_hit && !tlb_hit;
    assign tlb_miss  = (state_q == ST_MISS);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept && look_miss) state_d = ST_MISS;
            ST_MISS:  if (flush || rf_valid)   state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            if (win_hit) begin
                rsp_hit   <= 1'b1;
                rsp_fault <= 1'b0;
                rsp_paddr <= lk_addr;
            end else if (tlb_hit && lk_write && tlb_wp) begin
                rsp_hit   <= 1'b0;
                rsp_fault <= 1'b1;
                rsp_paddr <= '0;
            end else if (tlb_hit) begin
                rsp_hit   <= 1'b1;
                rsp_fault <= 1'b0;
                rsp_paddr <= {tlb_ppn, lk_addr[PAGE_BITS-1:0]};
            end else begin
                rsp_hit   <= 1'b0;
                rsp_fault <= 1'b0;
                rsp_paddr <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
        end
    end

    assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));
    assert_hit_fault_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_fault}));
    assert_miss_has_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_miss) |-> (rsp_valid && !rsp_hit && !rsp_fault));
    assert_miss_blocks_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss |=> !rsp_valid);
    assert_refill_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_miss && rf_valid) |=> !tlb_miss);
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!tlb_miss && !rsp_valid));
    assert_window_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit) |=> (rsp_hit && !rsp_fault && rsp_paddr == $past(lk_addr)));
    assert_window_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit && !rf_valid) |=> $stable(valid_vec));
endmodule

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;
    localparam int N = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        lk_ready;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        tlb_miss;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_lpn = '0, rf_ppn = '0;
    logic        rf_wp = 1'b0;
    logic        flush = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [7:0]  cfg_base = '0, cfg_mask = '0;
    logic        cfg_en = 1'b0;

    always #2 clk = ~clk;

    xlat_unit dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .tlb_miss(tlb_miss),
        .rf_valid(rf_valid), .rf_lpn(rf_lpn), .rf_ppn(rf_ppn), .rf_wp(rf_wp),
        .flush(flush),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model
    bit          m_valid [N];
    logic [19:0] m_lpn [N];
    logic [19:0] m_ppn [N];
    bit          m_wp [N];
    int          m_rr = 0;
    bit          m_miss = 0;
    logic [31:0] m_pa = '0;
    bit          w_en [2];
    logic [7:0]  w_base [2];
    logic [7:0]  w_mask [2];

    function automatic bit win_match(logic [31:0] a);
        for (int w = 0; w < 2; w++)
            if (w_en[w] && (((a[31:24] ^ w_base[w]) & ~w_mask[w]) == 8'h00)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int tlb_find(logic [19:0] l);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_lpn[i] == l) return i;
        return -1;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < N; i++)
            if (!m_valid[i]) return i;
        return -1;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_write = 0; rf_valid = 0; flush = 0; cfg_we = 0;
    endtask

    // One clock: predict, step, compare, update model.
    task automatic cycle(string tag);
        bit acc, e_hit, e_fault, missed;
        int idx, tgt;
        acc = lk_valid && !m_miss && !flush;
        e_hit = 0; e_fault = 0; missed = 0;
        if (acc) begin
            if (win_match(lk_addr)) begin
                e_hit = 1; m_pa = lk_addr;
            end else begin
                idx = tlb_find(lk_addr[31:12]);
                if (idx >= 0 && lk_write && m_wp[idx]) begin
                    e_fault = 1; m_pa = '0;
                end else if (idx >= 0) begin
                    e_hit = 1; m_pa = {m_ppn[idx], lk_addr[11:0]};
                end else begin
                    missed = 1; m_pa = '0;
                end
            end
        end
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(acc));
        chk(tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk(tag, "rsp_fault", 32'(rsp_fault), 32'(e_fault));
        chk(tag, "rsp_paddr", rsp_paddr, m_pa);
        if (flush) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            m_rr = 0; m_miss = 0;
        end else begin
            if (rf_valid) begin
                tgt = tlb_find(rf_lpn);
                if (tgt < 0) tgt = first_free();
                if (tgt < 0) begin
                    tgt = m_rr; m_rr = (m_rr + 1) % N;
                end
                m_valid[tgt] = 1; m_lpn[tgt] = rf_lpn; m_ppn[tgt] = rf_ppn; m_wp[tgt] = rf_wp;
            end
            if (acc && missed) m_miss = 1;
            else if (m_miss && rf_valid) m_miss = 0;
        end
        if (cfg_we) begin
            w_en[cfg_sel] = cfg_en; w_base[cfg_sel] = cfg_base; w_mask[cfg_sel] = cfg_mask;
        end
        chk(tag, "tlb_miss", 32'(tlb_miss), 32'(m_miss));
        chk(tag, "lk_ready", 32'(lk_ready), 32'(!m_miss));
        idle_inputs();
    endtask

    task automatic look(string tag, logic [31:0] a, bit wr);
        lk_valid = 1; lk_addr = a; lk_write = wr; cycle(tag);
    endtask

    task automatic refill(string tag, logic [19:0] l, logic [19:0] p, bit wp);
        rf_valid = 1; rf_lpn = l; rf_ppn = p; rf_wp = wp; cycle(tag);
    endtask

    task automatic cfg(string tag, bit s, logic [7:0] b, logic [7:0] m, bit e);
        cfg_we = 1; cfg_sel = s; cfg_base = b; cfg_mask = m; cfg_en = e; cycle(tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int w = 0; w < 2; w++) begin w_en[w] = 0; w_base[w] = 0; w_mask[w] = 0; end
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_lpn[i] = 0; m_ppn[i] = 0; m_wp[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1", "tlb_miss", 32'(tlb_miss), 0);
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "lk_ready", 32'(lk_ready), 1);
        look("R1", 32'h1000_0123, 0);                // empty cache misses
        look("R6", 32'h1000_0123, 0);                // ignored while miss held
        refill("R7", 20'h10000, 20'hABCDE, 1);       // releases miss
        look("R4", 32'h1000_0456, 0);
        look("R5", 32'h1000_0456, 1);                // write-protected
        cfg("R11", 0, 8'h10, 8'h00, 1);
        look("R2", 32'h1000_0456, 1);                // window beats protected entry
        look("R2", 32'h10FF_F789, 0);                // window hit, page not cached
        cfg("R11", 1, 8'h80, 8'h0F, 1);
        look("R2", 32'h8F00_0010, 1);
        look("R2", 32'h9000_0010, 0);                // outside mask -> miss
        refill("R7", 20'h90000, 20'h12345, 0);
        cfg("R3", 0, 8'h10, 8'h00, 0);
        look("R3", 32'h10FF_F789, 0);                // no allocation earlier -> miss
        refill("R7", 20'h10FFF, 20'h0F0F0, 0);
        // Fill and overflow the cache
        for (int i = 0; i < 30; i++) refill("R8", 20'h20000 + 20'(i), 20'h40000 + 20'(i), i[0]);
        for (int i = 0; i < 30; i++) begin
            look("R8", {12'h200, 8'(i), 12'h0AC}, 0);
            if (tlb_miss) refill("R8", 20'h20000 + 20'(i), 20'h50000 + 20'(i), 0);
        end
        refill("R9", 20'h2001C, 20'h77777, 1);       // remap existing page
        look("R9", 32'h2001_C008, 0);
        look("R9", 32'h2001_C008, 1);
        flush = 1; lk_valid = 1; lk_addr = 32'h2001_C008; rf_valid = 1; rf_lpn = 20'h33333;
        cycle("R10");
        look("R10", 32'h3333_3000, 0);
        look("R10", 32'h3333_3000, 0);
        flush = 1; cycle("R10");                     // flush releases miss
        // Random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 5000; n++) begin
            int op;
            logic [7:0] tops [5] = '{8'h10, 8'h20, 8'h80, 8'h8F, 8'hC0};
            logic [7:0] masks [4] = '{8'h00, 8'h0F, 8'hF0, 8'hFF};
            logic [31:0] a;
            op = int'($urandom_range(99));
            a = {tops[$urandom_range(4)], 7'h0, 5'($urandom_range(31)), 12'($urandom)};
            if (m_miss) begin
                if (op < 60) begin
                    rf_valid = 1; rf_lpn = a[31:12]; rf_ppn = 20'($urandom); rf_wp = 1'($urandom);
                end else if (op < 65) flush = 1;
                else begin lk_valid = 1; lk_addr = a; end
                cycle("R6");
            end else if (op < 60) begin
                lk_valid = 1; lk_addr = a; lk_write = 1'($urandom);
                if (op < 8) begin rf_valid = 1; rf_lpn = 20'($urandom); rf_ppn = 20'($urandom); end
                cycle("R4");
            end else if (op < 80) begin
                rf_valid = 1; rf_lpn = a[31:12]; rf_ppn = 20'($urandom); rf_wp = 1'($urandom);
                cycle("R8");
            end else if (op < 92) begin
                cfg_we = 1; cfg_sel = 1'($urandom); cfg_base = tops[$urandom_range(4)];
                cfg_mask = masks[$urandom_range(3)]; cfg_en = ($urandom_range(2) == 0);
                cycle("R11");
            end else if (op < 95) begin
                flush = 1; cycle("R10");
            end else cycle("R1");
        end
        finish_run();
    end
endmodule